// File: doc/BRIEF.md
# HDLC Transmit Framer

The framer turns a stream of frame bytes into a serial HDLC bitstream. While no frame is waiting the line carries back-to-back flag octets. When a frame is offered it opens it with a flag, sends each byte least significant bit first, and inserts a zero after every run of five ones in the body. It then appends a 16-bit or 32-bit frame check sequence and closes with a flag. Before the next frame may begin it sends a programmable minimum number of flags.

The line advances one bit per cycle in which the bit-clock enable is high. Bytes are taken through a valid/ready/last handshake, and the byte source must keep up with the line. If the source has no byte when one is needed, the framer closes the frame early with a correct check sequence over the bytes already sent, and raises a one-cycle underrun pulse.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is applied `tx_bit` is 1 and `in_ready` and `underrun` are 0. With no frame pending the line carries repeated flags 01111110 and no frame body.
- R2: Each frame is opened and closed by a flag. Its data bytes appear in the order accepted, each sent bit 0 first. Every accepted byte with `in_last`=1 ends the data of its frame.
- R3: Inside the data and check sequence bits, a 0 is inserted after every five consecutive ones. No zero is inserted inside flags, so the line never shows more than six consecutive ones.
- R4: With `fcs32_sel`=0 sampled when the frame starts, the check sequence is 16 bits. It uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to 0xFFFF, over the data bits in line order. The ones-complement is sent bit 0 first.
- R5: With `fcs32_sel`=1 sampled when the frame starts, the check sequence is 32 bits. It uses the reflected polynomial 0xEDB88320 (the 0x04C11DB7 generator), preset to 0xFFFFFFFF. The ones-complement is sent bit 0 first.
- R6: With the next frame already offered, exactly N flags lie between the last check sequence bit and the next frame's first data bit, the closing flag included. N is 2*`spacing`, or 1 when `spacing` is 0, and `spacing` is read when the check sequence ends. With N=1 one flag both closes a frame and opens the next.
- R7: `in_ready` is high only in a cycle where `bit_en` and `in_valid` are high and the framer needs a byte. A byte is taken on the clock edge where `in_valid` and `in_ready` are both high.
- R8: If `in_valid` is low when a frame needs its next byte, the framer sends the check sequence over the bytes already taken and closes the frame. `underrun` is high for exactly one cycle, following a cycle with `bit_en` high.
- R9: `tx_bit` changes only on a clock edge at which `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| fcs32_sel | input | 1 | 1 selects the 32-bit check sequence, 0 the 16-bit one |
| spacing | input | 5 | Flag-spacing setting n (N = 2n flags, 1 flag when n is 0) |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The offered byte is the last of its frame |
| in_ready | output | 1 | The framer takes the offered byte at this edge |
| tx_bit | output | 1 | Serial line data |
| underrun | output | 1 | One-cycle pulse when a frame ends for lack of data |

## Verification
The bench builds the framer with its default parameters: 8-bit bytes and a 5-bit spacing field. With these values the whole spacing range fits in a short run, up to the 62-flag maximum. Runs of all-ones bytes push zero insertion across byte boundaries and into the check sequence. An independent receiver model in the bench removes the inserted zeros, finds the flags, counts the flags between frames, and checks each frame's bytes and check sequence against a byte-wise CRC computed in the bench. It does this while the bit enable runs every cycle, every third cycle and in a pseudo-random pattern.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2,
    ST_TAIL = 2'd3
  } tx_state_e;

  localparam logic [7:0]  FLAG_OCTET   = 8'h7E;
  localparam int          SPC_W        = 5;
  localparam int          GAP_W        = SPC_W + 1;
  localparam int          STUFF_RUN    = 5;
  localparam logic [31:0] CRC16_REFL   = 32'h0000_8408;
  localparam logic [31:0] CRC32_REFL   = 32'hEDB8_8320;

  // Minimum flag count between frames for a spacing setting.
  function automatic logic [GAP_W-1:0] flags_for_setting(input logic [SPC_W-1:0] n);
    if (n == '0) return GAP_W'(1);
    return {n, 1'b0};
  endfunction

endpackage

// File: rtl/hdlc_crc_serial.sv
module hdlc_crc_serial #(
  parameter int               WIDTH    = 16,
  parameter logic [WIDTH-1:0] POLY_REF = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_init,
  input  logic en_update,
  input  logic en_shift,
  input  logic din,
  output logic fcs_bit
);

  logic [WIDTH-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en_init) begin
      crc_d = '1;
    end else if (en_update) begin
      crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ din) ? POLY_REF : '0);
    end else if (en_shift) begin
      crc_d = {1'b1, crc_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/hdlc_stuff_track.sv
module hdlc_stuff_track #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic body,
  input  logic bit_val,
  output logic due
);

  localparam int CNT_W = $clog2(RUN + 1);

  logic [CNT_W-1:0] ones_q, ones_d;

  always_comb begin
    ones_d = ones_q;
    if (step) begin
      if (!body || !bit_val)        ones_d = '0;
      else if (ones_q != CNT_W'(RUN)) ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign due = (ones_q == CNT_W'(RUN));

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fcs32_sel,
  input  logic [SPC_W-1:0]  spacing,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              stuff_due,
  input  logic              fcs_bit,
  output logic              in_ready,
  output logic              crc_init,
  output logic              crc_update,
  output logic              crc_shift,
  output logic              crc_din,
  output logic              fcs_long,
  output logic              body_bit,
  output logic              line_bit,
  output logic              tx_bit,
  output logic              underrun
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q, state_d;
  logic [2:0]        fidx_q, fidx_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d, cur_idx;
  logic              need_q, need_d;
  logic              last_q, last_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [4:0]        fcnt_q, fcnt_d;
  logic [GAP_W-1:0]  gap_q, gap_d, gap_new;
  logic [GAP_W-1:0]  req_q, req_d;
  logic              long_q, long_d;
  logic              txb_q, txb_d;
  logic              urun_q, urun_d;
  logic              do_fcs, do_flag, data_bit;

  always_comb begin
    state_d = state_q;  fidx_d = fidx_q;  bidx_d = bidx_q;  need_d = need_q;
    last_d  = last_q;   shreg_d = shreg_q; fcnt_d = fcnt_q; gap_d = gap_q;
    req_d   = req_q;    long_d = long_q;  txb_d = txb_q;   urun_d = 1'b0;
    in_ready = 1'b0; crc_init = 1'b0; crc_update = 1'b0; crc_shift = 1'b0;
    crc_din = 1'b0;  body_bit = 1'b0; line_bit = txb_q;
    do_fcs = 1'b0;   do_flag = 1'b0;  data_bit = 1'b0;  gap_new = gap_q;
    cur_idx = need_q ? '0 : bidx_q;

    if (bit_en) begin
      case (state_q)
        ST_DATA: begin
          if (stuff_due) begin
            line_bit = 1'b0;
            body_bit = 1'b1;
          end else if (need_q && !in_valid) begin
            urun_d = 1'b1;
            do_fcs = 1'b1;
          end else begin
            body_bit = 1'b1;
            if (need_q) begin
              in_ready = 1'b1;
              shreg_d  = in_data;
              last_d   = in_last;
              data_bit = in_data[0];
            end else begin
              data_bit = shreg_q[bidx_q];
            end
            line_bit   = data_bit;
            crc_update = 1'b1;
            crc_din    = data_bit;
            need_d     = 1'b0;
            bidx_d     = cur_idx + 1'b1;
            if (cur_idx == IDX_W'(DATA_W - 1)) begin
              bidx_d = '0;
              if (need_q ? in_last : last_q) state_d = ST_FCS;
              else                           need_d  = 1'b1;
            end
          end
        end
        ST_FCS: begin
          if (stuff_due) begin
            line_bit = 1'b0;
            body_bit = 1'b1;
          end else begin
            do_fcs = 1'b1;
          end
        end
        ST_TAIL: begin
          if (stuff_due) begin
            line_bit = 1'b0;
            body_bit = 1'b1;
          end else begin
            do_flag = 1'b1;
          end
        end
        default: do_flag = 1'b1;
      endcase

      if (do_fcs) begin
        line_bit  = fcs_bit;
        body_bit  = 1'b1;
        crc_shift = 1'b1;
        state_d   = ST_FCS;
        fcnt_d    = fcnt_q + 1'b1;
        if (fcnt_q == (long_q ? 5'd31 : 5'd15)) begin
          state_d = ST_TAIL;
          gap_d   = '0;
          req_d   = flags_for_setting(spacing);
        end
      end

      if (do_flag) begin
        line_bit = FLAG_OCTET[fidx_q];
        fidx_d   = fidx_q + 1'b1;
        state_d  = ST_FLAG;
        if (fidx_q == 3'd7) begin
          gap_new = (gap_q == '1) ? gap_q : gap_q + 1'b1;
          gap_d   = gap_new;
          if (gap_new >= req_q && in_valid) begin
            state_d  = ST_DATA;
            need_d   = 1'b1;
            bidx_d   = '0;
            fcnt_d   = '0;
            long_d   = fcs32_sel;
            crc_init = 1'b1;
          end
        end
      end

      txb_d = line_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLAG;  fidx_q <= '0;  bidx_q <= '0;  need_q <= 1'b0;
      last_q  <= 1'b0;     shreg_q <= '0; fcnt_q <= '0;  gap_q <= '0;
      req_q   <= GAP_W'(1); long_q <= 1'b0; txb_q <= 1'b1; urun_q <= 1'b0;
    end else begin
      state_q <= state_d;  fidx_q <= fidx_d;  bidx_q <= bidx_d;  need_q <= need_d;
      last_q  <= last_d;   shreg_q <= shreg_d; fcnt_q <= fcnt_d; gap_q <= gap_d;
      req_q   <= req_d;    long_q <= long_d;  txb_q <= txb_d;   urun_q <= urun_d;
    end
  end

  assign fcs_long = long_q;
  assign tx_bit   = txb_q;
  assign underrun = urun_q;

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              fcs32_sel,
  input  logic [SPC_W-1:0]  spacing,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit,
  output logic              underrun
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic       crc_init, crc_update, crc_shift, crc_din, fcs_long;
  logic       body_bit, line_bit, stuff_due;
  logic [1:0] fcs_bits;

  // Index 0: 16-bit check sequence, index 1: 32-bit check sequence.
  for (genvar g = 0; g < 2; g++) begin : g_crc
    localparam int          CW = (g == 0) ? 16 : 32;
    localparam logic [31:0] CP = (g == 0) ? CRC16_REFL : CRC32_REFL;
    hdlc_crc_serial #(.WIDTH(CW), .POLY_REF(CP[CW-1:0])) u_crc (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .en_init   (crc_init),
      .en_update (crc_update),
      .en_shift  (crc_shift),
      .din       (crc_din),
      .fcs_bit   (fcs_bits[g])
    );
  end

  hdlc_stuff_track #(.RUN(STUFF_RUN)) u_stuff (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (bit_en),
    .body    (body_bit),
    .bit_val (line_bit),
    .due     (stuff_due)
  );

  hdlc_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bit_en     (bit_en),
    .fcs32_sel  (fcs32_sel),
    .spacing    (spacing),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .stuff_due  (stuff_due),
    .fcs_bit    (fcs_long ? fcs_bits[1] : fcs_bits[0]),
    .in_ready   (in_ready),
    .crc_init   (crc_init),
    .crc_update (crc_update),
    .crc_shift  (crc_shift),
    .crc_din    (crc_din),
    .fcs_long   (fcs_long),
    .body_bit   (body_bit),
    .line_bit   (line_bit),
    .tx_bit     (tx_bit),
    .underrun   (underrun)
  );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_ready,
  input logic tx_bit,
  input logic underrun
);

  logic       en_d;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      run_q <= '0;
    end else begin
      en_d <= bit_en;
      if (en_d) run_q <= tx_bit ? ((run_q == 3'd7) ? run_q : run_q + 1'b1) : 3'd0;
    end
  end

  a_r7_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && in_valid));

  a_r9_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(tx_bit));

  a_r8_underrun_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  a_r8_underrun_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(bit_en));

  a_r3_run_of_ones_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 3'd6);

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bit_en   (bit_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .tx_bit   (tx_bit),
  .underrun (underrun)
);

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       fcs32_sel;
  logic [4:0] spacing;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_last;
  logic       in_ready;
  logic       tx_bit;
  logic       underrun;

  always #10 clk = ~clk;

  hdlc_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fcs32_sel(fcs32_sel),
    .spacing(spacing), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .tx_bit(tx_bit), .underrun(underrun)
  );

  int checks = 0;
  int errors = 0;
  int en_mode = 0;

  // scoreboard queues
  logic [7:0] exp_bytes [$];
  int         exp_len   [$];
  bit         exp_wide  [$];
  int         exp_gap   [$];
  logic [7:0] frm       [$];

  // monitor state
  logic bq [$];
  int   ones = 0;
  bit   synced = 0;
  int   gap_cnt = 0;
  int   flags_total = 0;
  int   frames_rx = 0;
  int   hold_viol = 0;
  int   rdy_viol = 0;
  int   urun_cnt = 0;
  logic last_tx = 1'b1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input bit wide, input logic [7:0] d [$]);
    logic [31:0] c, p;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    p = wide ? 32'hEDB8_8320 : 32'h0000_8408;
    foreach (d[i]) begin
      c ^= {24'h0, d[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
    end
    return wide ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic frame_end();
    int n, len, g, nf;
    bit wide, ok;
    logic [7:0] rx [$];
    logic [7:0] pl [$];
    logic [31:0] fcs_rx, fcs_ex;
    n = bq.size();
    frames_rx++;
    check(n % 8 == 0, "R2", "frame bit count multiple of 8", n, 0);
    for (int i = 0; i + 8 <= n; i += 8) begin
      logic [7:0] b;
      for (int j = 0; j < 8; j++) b[j] = bq[i + j];
      rx.push_back(b);
    end
    if (exp_len.size() == 0) begin
      check(0, "R2", "unexpected frame", rx.size(), 0);
      return;
    end
    len = exp_len.pop_front(); wide = exp_wide.pop_front(); g = exp_gap.pop_front();
    for (int i = 0; i < len; i++) pl.push_back(exp_bytes.pop_front());
    nf = wide ? 4 : 2;
    check(rx.size() == len + nf, "R2", "frame octet count", rx.size(), len + nf);
    if (rx.size() != len + nf) return;
    ok = 1;
    for (int i = 0; i < len; i++) if (rx[i] != pl[i]) begin
      if (ok) check(0, "R3", "payload byte after zero removal", rx[i], pl[i]);
      ok = 0;
    end
    if (ok) check(1, "R2", "payload", 0, 0);
    fcs_rx = '0;
    for (int i = 0; i < nf; i++) fcs_rx[8*i +: 8] = rx[len + i];
    fcs_ex = ref_fcs(wide, pl);
    if (wide) check(fcs_rx == fcs_ex, "R5", "32-bit check sequence", fcs_rx, fcs_ex);
    else      check(fcs_rx == fcs_ex, "R4", "16-bit check sequence", fcs_rx, fcs_ex);
    if (g >= 0) check(gap_cnt == g, "R6", "flags between frames", gap_cnt, g);
  endtask

  task automatic flag_seen();
    flags_total++;
    if (!synced) begin
      synced = 1;
      bq.delete();
      return;
    end
    for (int i = 0; i < 7; i++) if (bq.size() > 0) void'(bq.pop_back());
    if (bq.size() > 0) begin
      frame_end();
      gap_cnt = 1;
    end else begin
      gap_cnt++;
    end
    bq.delete();
  endtask

  task automatic rx_bit(input logic b);
    if (b) begin
      ones++;
      bq.push_back(1'b1);
      if (ones > 6) begin synced = 0; bq.delete(); end
    end else if (ones == 5) begin
      ones = 0;
    end else if (ones == 6) begin
      ones = 0;
      flag_seen();
    end else begin
      ones = 0;
      bq.push_back(1'b0);
    end
  endtask

  // monitor
  initial begin
    logic en_s;
    forever begin
      @(posedge clk);
      en_s = bit_en;
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (en_s) rx_bit(tx_bit);
        else if (tx_bit !== last_tx) hold_viol++;
        if (in_ready && !bit_en) rdy_viol++;
        if (underrun) urun_cnt++;
      end
      last_tx = tx_bit;
    end
  end

  // bit-clock enable generator
  initial begin
    int ph = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit_en = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      case (en_mode)
        0: bit_en = 1'b1;
        1: begin ph = (ph + 1) % 3; bit_en = (ph == 0); end
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          bit_en = lfsr[0];
        end
      endcase
    end
  end

  task automatic send_frame(input bit wide, input int gap, input bit with_last);
    exp_len.push_back(frm.size());
    exp_wide.push_back(wide);
    exp_gap.push_back(gap);
    foreach (frm[i]) exp_bytes.push_back(frm[i]);
    foreach (frm[i]) begin
      in_data   = frm[i];
      in_last   = with_last && (i == frm.size() - 1);
      in_valid  = 1'b1;
      fcs32_sel = wide;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    while (exp_len.size() != 0) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=%0d expected=0", exp_len.size());
    summary();
    $finish;
  end

  initial begin
    int f0;
    rst_n = 1'b0; fcs32_sel = 1'b0; spacing = 5'd0;
    in_data = '0; in_valid = 1'b0; in_last = 1'b0;
    repeat (5) @(negedge clk);
    check(tx_bit == 1'b1, "R1", "tx_bit in reset", tx_bit, 1);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    check(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: idle flags
    f0 = flags_total;
    repeat (200) @(negedge clk);
    check(flags_total - f0 >= 20, "R1", "idle flag count", flags_total - f0, 20);
    check(frames_rx == 0, "R1", "no frame while idle", frames_rx, 0);

    // spacing 0, 16-bit FCS, bit every cycle; R3 stuffing-heavy bytes
    spacing = 5'd0;
    frm = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};  send_frame(0, -1, 1);
    frm = '{8'h7E, 8'h7E, 8'h3F};         send_frame(0, 1, 1);
    frm = '{8'h00};                       send_frame(0, 1, 1);
    drain();

    // spacing 1 (2 flags), mixed FCS
    spacing = 5'd1;
    frm.delete(); for (int i = 0; i < 8; i++) frm.push_back(8'(i * 37 + 5));
    send_frame(1, -1, 1);
    send_frame(0, 2, 1);
    frm = '{8'hF8, 8'h1F, 8'hFF};        send_frame(1, 2, 1);
    drain();

    // R6 maximum spacing 31 (62 flags), bit every third cycle
    en_mode = 1; spacing = 5'd31;
    frm = '{8'hF8, 8'h1F, 8'hFC, 8'h3F, 8'h01, 8'h80};
    send_frame(0, -1, 1);
    send_frame(0, 62, 1);
    drain();

    // spacing 5 (10 flags), 32-bit FCS, random bit enable
    en_mode = 2; spacing = 5'd5;
    frm.delete(); for (int i = 0; i < 20; i++) frm.push_back(8'(i * 73) ^ 8'hA5);
    send_frame(1, -1, 1);
    send_frame(1, 10, 1);
    frm = '{8'hFF, 8'hFF};               send_frame(1, 10, 1);
    drain();
    check(urun_cnt == 0, "R8", "no underrun with data supplied", urun_cnt, 0);

    // R8: underrun after three bytes with no last
    en_mode = 0; spacing = 5'd0;
    frm = '{8'hAA, 8'h55, 8'hFF};        send_frame(0, -1, 0);
    drain();
    check(urun_cnt == 1, "R8", "underrun pulse count", urun_cnt, 1);
    frm = '{8'hFF, 8'hFE};               send_frame(0, -1, 1);
    drain();

    check(frames_rx == 13, "R2", "frames received", frames_rx, 13);
    check(exp_len.size() == 0, "R2", "frames outstanding", exp_len.size(), 0);
    check(hold_viol == 0, "R9", "tx_bit changes without bit_en", hold_viol, 0);
    check(rdy_viol == 0, "R7", "in_ready without bit_en", rdy_viol, 0);
    summary();
    $finish;
  end

endmodule